// File: doc/BRIEF.md
# Slave Packet FIFO with Auto-Commit

This block is the receive buffer behind a synchronous slave write port. An external master drives an address, an active-low chip select, an active-low write strobe and an active-low packet-end, together with a data word. The block collects the accepted words into packets and hands them to an upstream consumer as a valid/ready stream. The stream marks the final word of each packet with a last flag.

A packet closes in one of two ways. It closes automatically when the number of uncommitted words reaches a programmable length. It also closes on an explicit packet-end, which may arrive on the same edge as the last written word or on any later edge. Packet lengths are kept in a small descriptor queue beside the word storage, so the read side knows where each packet ends. The block also provides registered full and empty flags, and a sticky bit that records writes dropped while full.

Top module: `spf_top`

## Requirements
- R1: A word is stored on a rising edge only when chip select and write strobe are both low and the address equals the parameter EP_ADDR (default 0). Stored words leave the read stream in write order. Any other combination stores nothing.
- R2: With a programmed length L (1 to DEPTH), a packet of L words is committed on the edge that stores its L-th uncommitted word. L = 0 disables automatic commits.
- R3: A packet-end sampled on the same edge as an accepted write commits every uncommitted word, including that word.
- R4: A packet-end sampled on an edge without a write commits all words still uncommitted.
- R5: A packet-end on the edge that completes an automatic packet adds no packet of its own. A short packet forms only from a packet-end on a later edge that has uncommitted words.
- R6: A packet-end with no uncommitted words, including one on an empty FIFO, commits nothing.
- R7: rd_valid is high only while a committed word is waiting. rd_last is high on the final word of each packet. While rd_ready is low, rd_valid, rd_data and rd_last hold.
- R8: flag_full is registered and is high exactly when DEPTH words are stored. A write attempted while full is dropped and sets ovf_sticky, which stays set until reset.
- R9: flag_empty is registered and is high exactly when no word is stored, whether committed or not.
- R10: cfg_len is loaded into the length register on an edge with cfg_len_we high only while flag_empty is high. A load attempted while words are stored has no effect.
- R11: After reset, flag_empty = 1, flag_full = 0, ovf_sticky = 0, rd_valid = 0, and the length register holds RESET_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_addr | input | 2 | Endpoint address from the master |
| if_cs_n | input | 1 | Chip select, active low |
| if_wr_n | input | 1 | Write strobe, active low |
| if_pktend_n | input | 1 | Packet-end request, active low |
| if_data | input | DATA_W | Write data |
| cfg_len_we | input | 1 | Load strobe for the auto-commit length |
| cfg_len | input | LEN_W | Auto-commit length, 0 disables |
| rd_valid | output | 1 | A committed word is presented |
| rd_ready | input | 1 | Consumer accepts the presented word |
| rd_data | output | DATA_W | Presented word |
| rd_last | output | 1 | Presented word ends its packet |
| flag_full | output | 1 | Storage holds DEPTH words |
| flag_empty | output | 1 | Storage holds no word |
| ovf_sticky | output | 1 | A write was dropped while full |

## Verification
The bench sweeps every auto-commit length from 0 to 4 against every burst length that fits in the storage. Each combination is run twice: once with packet-end on the last word, and once with packet-end one edge later. Packet boundaries are computed arithmetically. A design that lets a coincident packet-end open a second packet produces an extra or empty packet. A design that drops the current word from a same-edge packet-end cuts the packet one word short. Further runs cover writing past full, packet-end on an empty FIFO, and a length load attempted while words are stored. A design that accepts the late load commits early, and a design that does not drop writes while full corrupts the data order.

// File: rtl/spf_pkg.sv
package spf_pkg;

   // Source of a packet commit on a given edge
   typedef enum logic [1:0] {
      CMT_NONE   = 2'd0,
      CMT_AUTO   = 2'd1,
      CMT_MANUAL = 2'd2
   } cmt_src_e;

endpackage

// File: rtl/spf_ram.sv
module spf_ram #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] store_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         store_q[waddr] <= wdata;
      end
   end

   assign rdata = store_q[raddr];

endmodule

// File: rtl/spf_desc_fifo.sv
module spf_desc_fifo #(
   parameter int LW    = 5,
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [LW-1:0] push_len,
   input  logic          pop,
   output logic [LW-1:0] head_len,
   output logic          nonempty,
   output logic          full
);

   logic [LW-1:0] len_q [DEPTH];
   logic [AW:0]   wp_q, rp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + 1'b1;
         if (pop)  rp_q <= rp_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         len_q[wp_q[AW-1:0]] <= push_len;
      end
   end

   assign head_len = len_q[rp_q[AW-1:0]];
   assign nonempty = (wp_q != rp_q);
   assign full     = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);

   // Each packet holds at least one stored word, so the queue can never overfill
   assert_desc_no_overfill_R7: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop));
   assert_desc_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> nonempty);

endmodule

// File: rtl/spf_commit_ctl.sv
module spf_commit_ctl
   import spf_pkg::*;
#(
   parameter int LW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_acc,
   input  logic          pkt_req,
   input  logic [LW-1:0] auto_len,
   output logic          commit_v,
   output logic [LW-1:0] commit_len,
   output cmt_src_e      commit_src
);

   logic [LW-1:0] ucnt_q;
   logic [LW-1:0] ucnt_inc;
   logic          auto_hit;

   assign ucnt_inc = ucnt_q + LW'(wr_acc);
   assign auto_hit = wr_acc && (auto_len != '0) && (ucnt_inc == auto_len);

   // Automatic completion takes the edge; a coincident packet-end then sees nothing left
   always_comb begin
      commit_src = CMT_NONE;
      if (auto_hit) begin
         commit_src = CMT_AUTO;
      end else if (pkt_req && (ucnt_inc != '0)) begin
         commit_src = CMT_MANUAL;
      end
   end

   assign commit_v   = (commit_src != CMT_NONE);
   assign commit_len = ucnt_inc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ucnt_q <= '0;
      end else if (commit_v) begin
         ucnt_q <= '0;
      end else begin
         ucnt_q <= ucnt_inc;
      end
   end

   assert_auto_len_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_src == CMT_AUTO) |-> (commit_len == auto_len));
   assert_open_below_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_len != '0) |-> (ucnt_q < auto_len));
   assert_no_empty_packet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      commit_v |-> (commit_len != '0));
   assert_commit_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      commit_v |=> (ucnt_q == '0));

endmodule

// File: rtl/spf_top.sv
module spf_top #(
   parameter int         DATA_W    = 16,
   parameter int         DEPTH     = 16,
   parameter logic [1:0] EP_ADDR   = 2'd0,
   parameter bit         AUTO_EN   = 1'b1,
   parameter int         LEN_W     = $clog2(DEPTH + 1),
   parameter int         RESET_LEN = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        if_addr,
   input  logic              if_cs_n,
   input  logic              if_wr_n,
   input  logic              if_pktend_n,
   input  logic [DATA_W-1:0] if_data,
   input  logic              cfg_len_we,
   input  logic [LEN_W-1:0]  cfg_len,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_last,
   output logic              flag_full,
   output logic              flag_empty,
   output logic              ovf_sticky
);
   import spf_pkg::*;

   localparam int AW = $clog2(DEPTH);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("spf_top: DEPTH must be a power of two of at least 2");
      assert (LEN_W >= $clog2(DEPTH + 1))
         else $error("spf_top: LEN_W too narrow for DEPTH");
      assert (DATA_W >= 1)
         else $error("spf_top: DATA_W must be positive");
      assert (RESET_LEN >= 0 && RESET_LEN <= DEPTH)
         else $error("spf_top: RESET_LEN out of range");
   end

   // Port qualification
   logic sel, wr_try, wr_acc, wr_drop, pkt_req, rd_fire;
   assign sel     = !if_cs_n && (if_addr == EP_ADDR);
   assign wr_try  = sel && !if_wr_n;
   assign wr_acc  = wr_try && !flag_full;
   assign wr_drop = wr_try && flag_full;
   assign pkt_req = sel && !if_pktend_n;

   // Auto-commit length register, present only in the auto variant
   logic [LEN_W-1:0] eff_len;
   generate
      if (AUTO_EN) begin : g_auto
         logic [LEN_W-1:0] len_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               len_q <= LEN_W'(RESET_LEN);
            end else if (cfg_len_we && flag_empty) begin
               len_q <= cfg_len;
            end
         end
         assign eff_len = len_q;

         assert_len_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !flag_empty |=> $stable(len_q));
      end else begin : g_manual
         logic unused_cfg;
         assign unused_cfg = ^{cfg_len_we, cfg_len};
         assign eff_len    = '0;
      end
   endgenerate

   // Commit decision
   logic             commit_v;
   logic [LEN_W-1:0] commit_len;
   cmt_src_e         commit_src;

   spf_commit_ctl #(.LW(LEN_W)) u_commit (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_acc     (wr_acc),
      .pkt_req    (pkt_req),
      .auto_len   (eff_len),
      .commit_v   (commit_v),
      .commit_len (commit_len),
      .commit_src (commit_src)
   );

   // Packet length queue
   logic [LEN_W-1:0] head_len;
   logic             dq_nonempty, dq_full, pop_pkt;

   spf_desc_fifo #(.LW(LEN_W), .DEPTH(DEPTH)) u_desc (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (commit_v),
      .push_len (commit_len),
      .pop      (pop_pkt),
      .head_len (head_len),
      .nonempty (dq_nonempty),
      .full     (dq_full)
   );

   // Word storage and pointers
   logic [AW-1:0]    wptr_q, rptr_q;
   logic [LEN_W-1:0] cnt_q, cnt_d, rpos_q;

   spf_ram #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_ram (
      .clk   (clk),
      .we    (wr_acc),
      .waddr (wptr_q),
      .wdata (if_data),
      .raddr (rptr_q),
      .rdata (rd_data)
   );

   assign rd_valid = dq_nonempty;
   assign rd_last  = (rpos_q == head_len - 1'b1);
   assign rd_fire  = rd_valid && rd_ready;
   assign pop_pkt  = rd_fire && rd_last;
   assign cnt_d    = cnt_q + LEN_W'(wr_acc) - LEN_W'(rd_fire);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q     <= '0;
         rptr_q     <= '0;
         rpos_q     <= '0;
         cnt_q      <= '0;
         flag_full  <= 1'b0;
         flag_empty <= 1'b1;
         ovf_sticky <= 1'b0;
      end else begin
         if (wr_acc)  wptr_q <= wptr_q + 1'b1;
         if (rd_fire) begin
            rptr_q <= rptr_q + 1'b1;
            rpos_q <= rd_last ? '0 : rpos_q + 1'b1;
         end
         if (wr_drop) ovf_sticky <= 1'b1;
         cnt_q      <= cnt_d;
         flag_full  <= (cnt_d == LEN_W'(DEPTH));
         flag_empty <= (cnt_d == '0);
      end
   end

   assert_drop_sets_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_drop |=> ovf_sticky);
   assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_sticky |=> ovf_sticky);
   assert_full_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flag_full == (cnt_q == LEN_W'(DEPTH)));
   assert_empty_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flag_empty == (cnt_q == '0));
   assert_empty_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flag_empty |-> !rd_valid);
   assert_hold_under_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last)));

endmodule

// File: tb/spf_top_bench.sv
module spf_top_bench;

   localparam int DW = 8;
   localparam int DP = 8;
   localparam int LW = 4;
   localparam logic [1:0] EP = 2'd0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    if_addr = 2'd0;
   logic          if_cs_n = 1'b1, if_wr_n = 1'b1, if_pktend_n = 1'b1;
   logic [DW-1:0] if_data = '0;
   logic          cfg_len_we = 1'b0;
   logic [LW-1:0] cfg_len = '0;
   logic          rd_ready = 1'b0;
   logic          rd_valid, rd_last, flag_full, flag_empty, ovf_sticky;
   logic [DW-1:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   spf_top #(.DATA_W(DW), .DEPTH(DP), .EP_ADDR(EP)) u_spf_top (
      .clk(clk), .rst_n(rst_n), .if_addr(if_addr), .if_cs_n(if_cs_n),
      .if_wr_n(if_wr_n), .if_pktend_n(if_pktend_n), .if_data(if_data),
      .cfg_len_we(cfg_len_we), .cfg_len(cfg_len), .rd_valid(rd_valid),
      .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
      .flag_full(flag_full), .flag_empty(flag_empty), .ovf_sticky(ovf_sticky)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One bus cycle: drive after a falling edge, return just after the rising edge
   task automatic put(input logic [1:0] a, input bit cs, input bit wr, input bit pk,
                      input logic [DW-1:0] d);
      @(negedge clk);
      if_addr = a; if_cs_n = !cs; if_wr_n = !wr; if_pktend_n = !pk; if_data = d;
      @(posedge clk);
      #1;
      if_cs_n = 1'b1; if_wr_n = 1'b1; if_pktend_n = 1'b1;
   endtask

   task automatic wrw(input int d, input bit pk);
      put(EP, 1'b1, 1'b1, pk, DW'(d));
   endtask

   task automatic pke();
      put(EP, 1'b1, 1'b0, 1'b1, '0);
   endtask

   task automatic setlen(input int l);
      @(negedge clk);
      cfg_len_we = 1'b1; cfg_len = LW'(l);
      @(posedge clk);
      #1;
      cfg_len_we = 1'b0;
   endtask

   // Read n words; full-length packets of l come first, the remainder forms one packet
   task automatic drain(input int n, input int l, input int base, input string tag);
      int nfull = (l == 0) ? 0 : n / l;
      for (int i = 0; i < n; i++) begin
         int exp_last;
         @(negedge clk);
         rd_ready = 1'b1;
         if (i < nfull * l) exp_last = ((i % l) == l - 1) ? 1 : 0;
         else               exp_last = (i == n - 1) ? 1 : 0;
         chk({tag, " R7 valid"}, int'(rd_valid), 1);
         chk({tag, " R1 data"},  int'(rd_data), (base + i) & 8'hFF);
         chk({tag, " R7 last"},  int'(rd_last), exp_last);
      end
      @(negedge clk);
      rd_ready = 1'b0;
      chk({tag, " R7 no phantom packet"}, int'(rd_valid), 0);
      chk({tag, " R9 empty after drain"}, int'(flag_empty), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 empty", int'(flag_empty), 1);
      chk("R11 full",  int'(flag_full), 0);
      chk("R11 ovf",   int'(ovf_sticky), 0);
      chk("R11 valid", int'(rd_valid), 0);

      // R6: packet-end on an empty FIFO
      pke();
      chk("R6 pktend on empty", int'(rd_valid), 0);
      chk("R6 still empty", int'(flag_empty), 1);

      // R1: writes that must be ignored
      put(2'd1, 1'b1, 1'b1, 1'b1, 8'h55);
      chk("R1 wrong address ignored", int'(flag_empty), 1);
      put(EP, 1'b0, 1'b1, 1'b1, 8'h56);
      chk("R1 chip select off ignored", int'(flag_empty), 1);
      chk("R1 no packet from ignored cycles", int'(rd_valid), 0);

      // Sweep: R2 auto length, R3 same-edge end, R4 later end, R5/R6 coincident cases
      for (int l = 0; l <= 4; l++) begin
         for (int n = 1; n < DP; n++) begin
            for (int m = 0; m < 2; m++) begin
               int base = l * 37 + n * 5 + m * 3;
               string tag = (l != 0) ? "R2" : ((m != 0) ? "R4" : "R3");
               setlen(l);
               for (int i = 0; i < n; i++) wrw(base + i, (m == 0) && (i == n - 1));
               if (m != 0) pke();
               drain(n, l, base, tag);
            end
         end
      end
      chk("R8 no overflow during sweep", int'(ovf_sticky), 0);

      // R5: end on auto-completing edge adds nothing; later end with data forms a short packet
      setlen(2);
      wrw(240, 1'b0);
      wrw(241, 1'b1);
      pke();
      wrw(242, 1'b0);
      pke();
      drain(3, 2, 240, "R5");

      // R4: end request on another address is ignored
      setlen(0);
      wrw(220, 1'b0);
      wrw(221, 1'b0);
      put(2'd2, 1'b1, 1'b0, 1'b1, '0);
      chk("R4 foreign address end ignored", int'(rd_valid), 0);
      pke();
      chk("R4 end commits pending words", int'(rd_valid), 1);
      // R7: stall holds the presented word
      @(negedge clk);
      chk("R7 stalled data", int'(rd_data), 220);
      @(negedge clk);
      @(negedge clk);
      chk("R7 data held", int'(rd_data), 220);
      chk("R7 valid held", int'(rd_valid), 1);
      drain(2, 0, 220, "R4");

      // R10: a load while words are stored is ignored
      wrw(200, 1'b0);
      setlen(1);
      wrw(201, 1'b0);
      wrw(202, 1'b0);
      chk("R10 late load ignored", int'(rd_valid), 0);
      pke();
      drain(3, 0, 200, "R10");
      setlen(1);
      wrw(210, 1'b0);
      chk("R10 load while empty takes effect", int'(rd_valid), 1);
      drain(1, 1, 210, "R10");

      // R8: fill, overfill, sticky overflow
      setlen(0);
      for (int i = 0; i < DP + 2; i++) begin
         wrw(100 + i, 1'b0);
         if (i == DP - 2) chk("R8 not full one short", int'(flag_full), 0);
         if (i == DP - 1) chk("R8 full at depth", int'(flag_full), 1);
      end
      chk("R8 overflow set", int'(ovf_sticky), 1);
      chk("R9 not empty when full", int'(flag_empty), 0);
      pke();
      drain(DP, 0, 100, "R8");
      chk("R8 full cleared", int'(flag_full), 0);
      chk("R8 overflow sticky", int'(ovf_sticky), 1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule